// File: doc/BRIEF.md
# Chipset DMA to SDRAM Adapter

This block lets a 16-bit chipset DMA engine use a 32-bit SDRAM. The engine uses asynchronous DRAM-style strobes: two row strobes, one for each bank, upper and lower column strobes, an active-low write enable, and a 10-bit multiplexed address. The block samples all of these on the bus clock. It keeps the row and the column, then plays them back as one SDRAM activate followed by one read or write command. Both commands carry auto-precharge, so the bank is idle again before the next access.

Bit 0 of the column selects which 16-bit half of the 32-bit SDRAM word is used. The upper and lower column strobes become byte masks inside that half. The same bit enables the data bridge to the lower word. When the bridge is enabled, its direction is the inverse of the DMA write enable.

Read data is captured one CAS latency after the read command. It is held until the chipset takes it, which is marked by a rising phase clock. A CPU request for the same memory is granted only in the gaps between DMA accesses.

Top module: `dma_sdram_bridge`

## Requirements
- R1: The first clock edge that samples either row strobe low stores `dma_addr` as the row. It also stores the bank: 0 when `row_stb_n[0]` is low, 1 otherwise. Both appear on `sd_addr` as `{1'b0,row}` and on `sd_ba` while `sd_act` is high.
- R2: A column strobe starts an access only if a row strobe was sampled low on an earlier edge and the block is idle. A column strobe with no row strobe has no effect.
- R3: Let edge k be the first edge that samples a column strobe low. `sd_act` is high for exactly the one cycle that follows edge k+1, so the SDRAM takes it at edge k+2.
- R4: In the cycle after the activate, exactly one of `sd_wr` (write enable was low at edge k) or `sd_rd` is high. `sd_addr` is then `{1'b1, 1'b0, col[9:1]}`, where the top bit is auto-precharge.
- R5: `half_lo` equals the stored column bit 0, where 1 means the lower half `[15:0]` and 0 means the upper half `[31:16]`. During a command, `sd_dqm` (1 = byte masked, bit i covers bits 8i+7:8i) masks both bytes of the other half. In the selected half it carries `{col_hi_n, col_lo_n}`. Outside a command it is `4'hF`.
- R6: During a write command `sd_wdata` is `{chip_wdata, chip_wdata}`.
- R7: For a read, the edge k+3+CAS_LAT loads `dma_rdata` with the selected half of `sd_dq_in` and sets `rd_valid`. `dma_rdata` then holds that value until the next read capture.
- R8: An edge that samples `phase1` rising while `rd_valid` is high clears `rd_valid` and leaves `dma_rdata` unchanged.
- R9: `bridge_en` is `dma_busy & col[0]`. `bridge_dir` is `bridge_en & ~we`, where 1 means from the chipset to the SDRAM.
- R10: `cpu_gnt` is high after an edge only if that edge sampled `cpu_req` high, all strobes high and the block idle. It is never high together with `dma_busy`.
- R11: `dma_busy` rises after edge k. After the command, and after the read latency for a read, the block returns to idle on the first edge that samples all strobes high.
- R12: While `rst_n` is low, every command, grant, busy, valid and bridge output is 0 and `sd_dqm` is `4'hF`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_stb_n | input | 2 | Row strobes, bank 0 and bank 1, active low |
| col_hi_n | input | 1 | Upper byte column strobe, active low |
| col_lo_n | input | 1 | Lower byte column strobe, active low |
| dma_we_n | input | 1 | DMA write enable, active low |
| dma_addr | input | 10 | Multiplexed row/column address |
| phase1 | input | 1 | Chipset phase clock; a rising edge means read data was taken |
| chip_wdata | input | 16 | DMA write data |
| sd_dq_in | input | 32 | SDRAM read data |
| cpu_req | input | 1 | CPU request for the memory |
| sd_act | output | 1 | SDRAM bank activate command |
| sd_rd | output | 1 | SDRAM read command with auto-precharge |
| sd_wr | output | 1 | SDRAM write command with auto-precharge |
| sd_ba | output | 1 | SDRAM bank |
| sd_addr | output | 11 | SDRAM address; top bit is auto-precharge |
| sd_dqm | output | 4 | SDRAM byte masks, 1 = masked |
| sd_wdata | output | 32 | SDRAM write data |
| dma_rdata | output | 16 | Read data held for the chipset |
| rd_valid | output | 1 | Read data waiting for the chipset |
| half_lo | output | 1 | 1 = lower word half selected |
| bridge_en | output | 1 | Data bridge enable |
| bridge_dir | output | 1 | Bridge direction, 1 = chipset to SDRAM |
| cpu_gnt | output | 1 | CPU access granted |
| dma_busy | output | 1 | DMA access in progress |

## Verification
Every result is counted from edge k, the first edge that samples a column strobe low. Busy, half select and the bridge are due after k. The activate is due after k+1 and the command, with its masks and write data, after k+2. Read data is loaded at k+3+CAS_LAT, and the grant returns one edge after the block goes idle. The bench drives the inputs on falling edges and checks each output at the falling edge just after the rising edge where it is due. The read bus carries a wrong pattern on every edge except the capture edge, so a capture one edge early or late loads the wrong value. Each check runs before the next change of input.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;
  localparam int MASK_W = WORD_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DLY,
    ST_ACT,
    ST_CMD,
    ST_LAT,
    ST_HOLD
  } seq_state_e;
endpackage

// File: rtl/dsb_capture.sv
module dsb_capture #(
  parameter int DRA_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       row_stb_n,
  input  logic             col_hi_n,
  input  logic             col_lo_n,
  input  logic             dma_we_n,
  input  logic [DRA_W-1:0] dma_addr,
  input  logic             idle,
  output logic             start,
  output logic             strobes_idle,
  output logic [DRA_W-1:0] row_q,
  output logic [DRA_W-1:0] col_q,
  output logic             bank_q,
  output logic             wr_q,
  output logic [1:0]       bmask_q
);
  logic             row_act, col_act;
  logic             row_seen_q, col_seen_q;
  logic             row_new;
  logic [DRA_W-1:0] row_d, col_d;
  logic             bank_d, wr_d;
  logic [1:0]       bmask_d;

  assign row_act      = ~&row_stb_n;
  assign col_act      = ~(col_hi_n & col_lo_n);
  assign row_new      = row_act & ~row_seen_q;
  assign start        = col_act & ~col_seen_q & row_seen_q & idle;
  assign strobes_idle = ~row_act & ~col_act;

  always_comb begin
    row_d   = row_q;
    bank_d  = bank_q;
    col_d   = col_q;
    wr_d    = wr_q;
    bmask_d = bmask_q;
    if (row_new) begin
      row_d  = dma_addr;
      bank_d = row_stb_n[0];
    end
    if (start) begin
      col_d   = dma_addr;
      wr_d    = ~dma_we_n;
      bmask_d = {col_hi_n, col_lo_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_seen_q <= 1'b0;
      col_seen_q <= 1'b0;
      row_q      <= '0;
      col_q      <= '0;
      bank_q     <= 1'b0;
      wr_q       <= 1'b0;
      bmask_q    <= 2'b11;
    end else begin
      row_seen_q <= row_act;
      col_seen_q <= col_act;
      row_q      <= row_d;
      col_q      <= col_d;
      bank_q     <= bank_d;
      wr_q       <= wr_d;
      bmask_q    <= bmask_d;
    end
  end
endmodule

// File: rtl/dsb_seq.sv
module dsb_seq
  import dsb_pkg::*;
#(
  parameter int CAS_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic strobes_idle,
  input  logic wr_q,
  output logic idle,
  output logic act,
  output logic cmd,
  output logic rd,
  output logic wr,
  output logic rd_cap
);
  localparam int CNT_W = $clog2(CAS_LAT + 1);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_IDLE: if (start) st_d = ST_DLY;
      ST_DLY:  st_d = ST_ACT;
      ST_ACT:  st_d = ST_CMD;
      ST_CMD: begin
        if (wr_q) begin
          st_d = ST_HOLD;
        end else begin
          st_d  = ST_LAT;
          cnt_d = CNT_W'(CAS_LAT - 1);
        end
      end
      ST_LAT: begin
        if (cnt_q == '0) st_d = ST_HOLD;
        else cnt_d = cnt_q - 1'b1;
      end
      ST_HOLD: if (strobes_idle) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign idle   = (st_q == ST_IDLE);
  assign act    = (st_q == ST_ACT);
  assign cmd    = (st_q == ST_CMD);
  assign rd     = cmd & ~wr_q;
  assign wr     = cmd & wr_q;
  assign rd_cap = (st_q == ST_LAT) && (cnt_q == '0);
endmodule

// File: rtl/dsb_datapath.sv
module dsb_datapath
  import dsb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd,
  input  logic              wr,
  input  logic              rd_cap,
  input  logic              busy,
  input  logic              phase1,
  input  logic              col0,
  input  logic              wr_q,
  input  logic [1:0]        bmask_q,
  input  logic [HALF_W-1:0] chip_wdata,
  input  logic [WORD_W-1:0] sd_dq_in,
  output logic [MASK_W-1:0] sd_dqm,
  output logic [WORD_W-1:0] sd_wdata,
  output logic [HALF_W-1:0] dma_rdata,
  output logic              rd_valid,
  output logic              bridge_en,
  output logic              bridge_dir
);
  logic [HALF_W-1:0] rdata_q, rdata_d;
  logic              valid_q, valid_d;
  logic              ph_q;

  always_comb begin
    rdata_d = rdata_q;
    valid_d = valid_q;
    if (rd_cap) begin
      rdata_d = col0 ? sd_dq_in[HALF_W-1:0] : sd_dq_in[WORD_W-1:HALF_W];
      valid_d = 1'b1;
    end else if (phase1 && !ph_q) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      valid_q <= 1'b0;
      ph_q    <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      valid_q <= valid_d;
      ph_q    <= phase1;
    end
  end

  always_comb begin
    if (!cmd)      sd_dqm = '1;
    else if (col0) sd_dqm = {2'b11, bmask_q};
    else           sd_dqm = {bmask_q, 2'b11};
  end

  assign sd_wdata   = wr ? {chip_wdata, chip_wdata} : '0;
  assign dma_rdata  = rdata_q;
  assign rd_valid   = valid_q;
  assign bridge_en  = busy & col0;
  assign bridge_dir = busy & col0 & wr_q;
endmodule

// File: rtl/dma_sdram_bridge.sv
module dma_sdram_bridge
  import dsb_pkg::*;
#(
  parameter int DRA_W   = 10,
  parameter int CAS_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        row_stb_n,
  input  logic              col_hi_n,
  input  logic              col_lo_n,
  input  logic              dma_we_n,
  input  logic [DRA_W-1:0]  dma_addr,
  input  logic              phase1,
  input  logic [HALF_W-1:0] chip_wdata,
  input  logic [WORD_W-1:0] sd_dq_in,
  input  logic              cpu_req,
  output logic              sd_act,
  output logic              sd_rd,
  output logic              sd_wr,
  output logic              sd_ba,
  output logic [DRA_W:0]    sd_addr,
  output logic [MASK_W-1:0] sd_dqm,
  output logic [WORD_W-1:0] sd_wdata,
  output logic [HALF_W-1:0] dma_rdata,
  output logic              rd_valid,
  output logic              half_lo,
  output logic              bridge_en,
  output logic              bridge_dir,
  output logic              cpu_gnt,
  output logic              dma_busy
);
  logic             start, strobes_idle, idle;
  logic             act, cmd, rd, wr, rd_cap;
  logic [DRA_W-1:0] row_q, col_q;
  logic             bank_q, wr_q;
  logic [1:0]       bmask_q;
  logic             gnt_q, gnt_d;

  dsb_capture #(.DRA_W(DRA_W)) cap_i (
    .clk(clk), .rst_n(rst_n), .row_stb_n(row_stb_n), .col_hi_n(col_hi_n),
    .col_lo_n(col_lo_n), .dma_we_n(dma_we_n), .dma_addr(dma_addr),
    .idle(idle), .start(start), .strobes_idle(strobes_idle),
    .row_q(row_q), .col_q(col_q), .bank_q(bank_q), .wr_q(wr_q),
    .bmask_q(bmask_q)
  );

  dsb_seq #(.CAS_LAT(CAS_LAT)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .strobes_idle(strobes_idle),
    .wr_q(wr_q), .idle(idle), .act(act), .cmd(cmd), .rd(rd), .wr(wr),
    .rd_cap(rd_cap)
  );

  dsb_datapath dp_i (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .wr(wr), .rd_cap(rd_cap),
    .busy(~idle), .phase1(phase1), .col0(col_q[0]), .wr_q(wr_q),
    .bmask_q(bmask_q), .chip_wdata(chip_wdata), .sd_dq_in(sd_dq_in),
    .sd_dqm(sd_dqm), .sd_wdata(sd_wdata), .dma_rdata(dma_rdata),
    .rd_valid(rd_valid), .bridge_en(bridge_en), .bridge_dir(bridge_dir)
  );

  always_comb begin
    if (act)      sd_addr = {1'b0, row_q};
    else if (cmd) sd_addr = {1'b1, 1'b0, col_q[DRA_W-1:1]};
    else          sd_addr = '0;
  end

  assign gnt_d = cpu_req & strobes_idle & idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gnt_q <= 1'b0;
    else        gnt_q <= gnt_d;
  end

  assign sd_act   = act;
  assign sd_rd    = rd;
  assign sd_wr    = wr;
  assign sd_ba    = bank_q;
  assign half_lo  = col_q[0];
  assign cpu_gnt  = gnt_q;
  assign dma_busy = ~idle;
endmodule

// File: rtl/dsb_checker.sv
module dsb_checker #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sd_act,
  input logic          sd_rd,
  input logic          sd_wr,
  input logic [AW-1:0] sd_addr,
  input logic [3:0]    sd_dqm,
  input logic          cpu_gnt,
  input logic          dma_busy,
  input logic          bridge_en,
  input logic          bridge_dir,
  input logic          rd_valid,
  input logic [15:0]   dma_rdata
);
  assert_act_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sd_act |=> !sd_act);
  assert_act_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sd_act |-> dma_busy);
  assert_cmd_follows_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sd_act |=> (sd_rd || sd_wr));
  assert_cmd_autopre_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_rd || sd_wr) |-> sd_addr[AW-1]);
  assert_cmd_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sd_act, sd_rd, sd_wr}));
  assert_other_half_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_rd || sd_wr) |-> (sd_dqm[3:2] == 2'b11 || sd_dqm[1:0] == 2'b11));
  assert_hold_on_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_valid) |-> $stable(dma_rdata));
  assert_bridge_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bridge_dir |-> bridge_en);
  assert_gnt_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_gnt && dma_busy));
endmodule

bind dma_sdram_bridge dsb_checker #(.AW(DRA_W + 1)) chk_i (
  .clk(clk), .rst_n(rst_n), .sd_act(sd_act), .sd_rd(sd_rd), .sd_wr(sd_wr),
  .sd_addr(sd_addr), .sd_dqm(sd_dqm), .cpu_gnt(cpu_gnt), .dma_busy(dma_busy),
  .bridge_en(bridge_en), .bridge_dir(bridge_dir), .rd_valid(rd_valid),
  .dma_rdata(dma_rdata)
);

// File: tb/dma_sdram_bridge_tb_top.sv
module dma_sdram_bridge_tb_top;
  localparam int CL = 2;

  typedef struct packed {
    logic        bank;
    logic [9:0]  row;
    logic [9:0]  col;
    logic        we;
    logic        um;
    logic        lm;
    logic [15:0] wd;
    logic [31:0] dq;
  } vec_t;

  localparam vec_t VEC [0:5] = '{
    '{1'b0, 10'h155, 10'h0AA, 1'b1, 1'b0, 1'b0, 16'hA5C3, 32'h0},
    '{1'b1, 10'h2AB, 10'h133, 1'b1, 1'b1, 1'b0, 16'h1234, 32'h0},
    '{1'b0, 10'h001, 10'h3FE, 1'b0, 1'b0, 1'b0, 16'h0,    32'hCAFEBEEF},
    '{1'b1, 10'h3FF, 10'h001, 1'b0, 1'b0, 1'b0, 16'h0,    32'h12345678},
    '{1'b0, 10'h0F0, 10'h2F1, 1'b1, 1'b0, 1'b1, 16'hFFFF, 32'h0},
    '{1'b1, 10'h100, 10'h056, 1'b0, 1'b0, 1'b1, 16'h0,    32'h89ABCDEF}
  };

  logic        clk, rst_n;
  logic [1:0]  row_stb_n;
  logic        col_hi_n, col_lo_n, dma_we_n, phase1, cpu_req;
  logic [9:0]  dma_addr;
  logic [15:0] chip_wdata;
  logic [31:0] sd_dq_in;
  logic        sd_act, sd_rd, sd_wr, sd_ba;
  logic [10:0] sd_addr;
  logic [3:0]  sd_dqm;
  logic [31:0] sd_wdata;
  logic [15:0] dma_rdata;
  logic        rd_valid, half_lo, bridge_en, bridge_dir, cpu_gnt, dma_busy;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] keep;

  dma_sdram_bridge #(.DRA_W(10), .CAS_LAT(CL)) dut_i (
    .clk(clk), .rst_n(rst_n), .row_stb_n(row_stb_n), .col_hi_n(col_hi_n),
    .col_lo_n(col_lo_n), .dma_we_n(dma_we_n), .dma_addr(dma_addr),
    .phase1(phase1), .chip_wdata(chip_wdata), .sd_dq_in(sd_dq_in),
    .cpu_req(cpu_req), .sd_act(sd_act), .sd_rd(sd_rd), .sd_wr(sd_wr),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_wdata(sd_wdata),
    .dma_rdata(dma_rdata), .rd_valid(rd_valid), .half_lo(half_lo),
    .bridge_en(bridge_en), .bridge_dir(bridge_dir), .cpu_gnt(cpu_gnt),
    .dma_busy(dma_busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v);
    logic [3:0] exp_m;
    step();
    row_stb_n = v.bank ? 2'b01 : 2'b10;
    dma_addr  = v.row;
    dma_we_n  = 1'b1;
    step();
    dma_addr   = v.col;
    col_hi_n   = v.um;
    col_lo_n   = v.lm;
    dma_we_n   = ~v.we;
    chip_wdata = v.wd;
    sd_dq_in   = ~v.dq;
    step();                                   // after edge k
    chk("R11 busy", {31'b0, dma_busy}, 32'd1);
    chk("R5 half_lo", {31'b0, half_lo}, {31'b0, v.col[0]});
    chk("R9 bridge_en", {31'b0, bridge_en}, {31'b0, v.col[0]});
    chk("R9 bridge_dir", {31'b0, bridge_dir}, {31'b0, v.col[0] & v.we});
    chk("R10 gnt low in dma", {31'b0, cpu_gnt}, 32'd0);
    chk("R3 no early act", {31'b0, sd_act}, 32'd0);
    step();                                   // after k+1
    chk("R3 act", {31'b0, sd_act}, 32'd1);
    chk("R1 row addr", {21'b0, sd_addr}, {21'b0, 1'b0, v.row});
    chk("R1 bank", {31'b0, sd_ba}, {31'b0, v.bank});
    chk("R4 no cmd with act", {30'b0, sd_rd, sd_wr}, 32'd0);
    step();                                   // after k+2
    exp_m = v.col[0] ? {2'b11, v.um, v.lm} : {v.um, v.lm, 2'b11};
    chk("R3 act single", {31'b0, sd_act}, 32'd0);
    chk("R4 cmd kind", {30'b0, sd_rd, sd_wr}, {30'b0, ~v.we, v.we});
    chk("R4 col addr", {21'b0, sd_addr}, {21'b0, 2'b10, v.col[9:1]});
    chk("R5 dqm", {28'b0, sd_dqm}, {28'b0, exp_m});
    if (v.we) begin
      chk("R6 wdata", sd_wdata, {v.wd, v.wd});
    end else begin
      repeat (CL) step();
      sd_dq_in = v.dq;
      step();                                 // after k+3+CL
      sd_dq_in = ~v.dq;
      chk("R7 rdata", {16'b0, dma_rdata}, {16'b0, v.col[0] ? v.dq[15:0] : v.dq[31:16]});
      chk("R7 valid", {31'b0, rd_valid}, 32'd1);
      step();
      chk("R7 rdata held", {16'b0, dma_rdata}, {16'b0, v.col[0] ? v.dq[15:0] : v.dq[31:16]});
    end
    row_stb_n = 2'b11;
    col_hi_n  = 1'b1;
    col_lo_n  = 1'b1;
    step();
    step();
    chk("R11 idle after release", {31'b0, dma_busy}, 32'd0);
    chk("R5 dqm idle", {28'b0, sd_dqm}, 32'hF);
    step();
    chk("R10 gnt in gap", {31'b0, cpu_gnt}, 32'd1);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    row_stb_n = 2'b11; col_hi_n = 1'b1; col_lo_n = 1'b1; dma_we_n = 1'b1;
    dma_addr = '0; phase1 = 1'b0; chip_wdata = '0; sd_dq_in = '0; cpu_req = 1'b0;
    repeat (3) step();
    chk("R12 reset cmds", {29'b0, sd_act, sd_rd, sd_wr}, 32'd0);
    chk("R12 reset dqm", {28'b0, sd_dqm}, 32'hF);
    chk("R12 reset flags", {28'b0, cpu_gnt, dma_busy, rd_valid, bridge_en}, 32'd0);
    rst_n = 1'b1;
    step();
    cpu_req = 1'b1;
    step();
    chk("R10 gnt when idle", {31'b0, cpu_gnt}, 32'd1);

    for (int i = 0; i < 6; i++) run_vec(VEC[i]);

    // R8: a rising phase1 clears valid and keeps the data
    keep = dma_rdata;
    phase1 = 1'b1;
    step();
    chk("R8 valid cleared", {31'b0, rd_valid}, 32'd0);
    chk("R8 data kept", {16'b0, dma_rdata}, {16'b0, keep});
    phase1 = 1'b0;

    // R2: a column strobe with no row strobe has no effect
    dma_addr = 10'h3C3;
    col_hi_n = 1'b0;
    col_lo_n = 1'b0;
    for (int j = 0; j < 5; j++) begin
      step();
      chk("R2 no busy", {31'b0, dma_busy}, 32'd0);
      chk("R2 no act", {31'b0, sd_act}, 32'd0);
    end
    col_hi_n = 1'b1;
    col_lo_n = 1'b1;
    step();

    // R10: a row strobe alone removes the grant
    row_stb_n = 2'b10;
    step();
    chk("R10 gnt drops on row strobe", {31'b0, cpu_gnt}, 32'd0);
    row_stb_n = 2'b11;
    step();
    step();
    chk("R10 gnt back", {31'b0, cpu_gnt}, 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule